// File: doc/BRIEF.md
# Hot-Plug Slot Register Block

This block holds the slot capability, slot control and slot status registers of a hot-plug capable downstream port, and turns them into the interrupt that software sees. Software reaches the registers through a small configuration port that carries 16-bit word reads and writes qualified by two byte enables. Two sideband pulses report a device being hot-added and the attention button being pressed. The block drives a level interrupt, a one-cycle message-request pulse with its 5-bit vector, a detach request for the secondary bus, and a busy pulse when a hot-add is refused.

Every write that touches slot control is one command and raises command-completed. Control also carries a write-only interlock toggle, the attention and power indicators, and the power-controller bit. Event status bits are write-one-to-clear. Each one adds to the notification level only when its own enable and the global hot-plug interrupt enable are both set. An interrupt or message is produced only when that level changes. Software that re-enables interrupts while events are still pending therefore gets a late notification.

Top module: `hps_slot_ctrl`

## Requirements
- R1: Register map by cfg_addr: 0 = vector register (bits [4:0] message number, read/write), 1 = slot control, 2 = slot status, 3 = capability (read-only, {SLOT_ID[10:0], 5'b11111}). Control layout: [0] button enable, [1] presence-change enable, [2] command-done enable, [3] hot-plug interrupt enable, [5:4] attention indicator, [7:6] power indicator (01 on, 10 blink, 11 off), [8] power off, [9] interlock toggle. After reset, control reads 0x0030 (attention indicator off, everything else clear), status reads 0 and the vector reads 0.
- R2: Status layout: [0] button pressed, [1] presence changed, [2] command completed, [3] presence state, [4] interlock engaged. Bits [2:0] clear when written with one in an enabled byte. Bits [3] and [4] ignore writes, and a write with both byte enables low changes nothing.
- R3: The notification level is high exactly when control bit 3 is set and, for at least one i in 0..2, both status bit i and control bit i are set.
- R4: With msg_enable low, irq_o equals the notification level, one clock after the register change that produced it.
- R5: With msg_enable high, irq_o stays low. msg_o pulses for one cycle, with msg_vec_o equal to the vector register, each time the level rises. A falling level sends nothing.
- R6: Setting the hot-plug interrupt enable while an enabled event is still pending raises the level and produces a notification.
- R7: A write to slot control with at least one byte enable set counts as one command and sets status bit 2. A write with no byte enabled is not a command.
- R8: Writing one to control bit 9 inverts status bit 4. Bit 9 always reads as zero.
- R9: A control write that leaves power off (bit 8) set and the power indicator at off (11), while presence state is set, pulses detach_o, clears presence state and sets presence changed. No detach happens otherwise.
- R10: A hot_add pulse sets presence state, presence changed and button pressed together. If the interlock is engaged, it is refused instead: add_busy_o pulses and status does not change.
- R11: button_press sets status bit 0. Pressing again while the bit is already set produces no further notification.
- R12: Clearing the enabled pending status bits through a status write drops irq_o in legacy mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| msg_enable | input | 1 | Message interrupts in use instead of the level line |
| hot_add | input | 1 | Hot-add event pulse |
| button_press | input | 1 | Attention button pulse |
| irq_o | output | 1 | Legacy level interrupt |
| msg_o | output | 1 | One-cycle message request |
| msg_vec_o | output | 5 | Message vector number |
| detach_o | output | 1 | Detach request for the secondary bus |
| add_busy_o | output | 1 | Hot-add refused because the interlock is engaged |

## Verification
The notification level is driven through a table of control settings, each paired with no event, a button press or a hot-add. The table separates a missing global enable, a missing per-event enable, and command-completed raised by the control write itself. Directed sequences then cover the message path: enabling the interrupt late while a press is pending has to give exactly one message, and a repeated press or a falling level has to give none. Separate cases split byte enables from commands, check the interlock toggle against a refused hot-add, and test the detach condition with the power indicator on and off and with the slot empty.

// File: rtl/hps_pkg.sv
package hps_pkg;
    localparam int CFG_W = 16;
    localparam int BE_W  = CFG_W / 8;
    localparam int VEC_W = 5;
    localparam int SLOT_ID_W = CFG_W - 5;

    localparam logic [1:0] IND_ON    = 2'b01;
    localparam logic [1:0] IND_BLINK = 2'b10;
    localparam logic [1:0] IND_OFF   = 2'b11;

    typedef struct packed {
        logic       pwr_off;
        logic [1:0] pwr_ind;
        logic [1:0] attn_ind;
        logic       hp_ie;
        logic       cc_en;
        logic       pd_en;
        logic       ab_en;
    } slot_ctl_t;

    typedef struct packed {
        logic lock;
        logic pds;
        logic cci;
        logic pdc;
        logic abp;
    } slot_sts_t;

    localparam int CTL_W    = $bits(slot_ctl_t);
    localparam int STS_W    = $bits(slot_sts_t);
    localparam int LOCK_BIT = CTL_W;
    localparam int REG_W    = CTL_W + 1;
endpackage

// File: rtl/hps_cfg_decode.sv
module hps_cfg_decode
    import hps_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    output logic              wr_vec,
    output logic              wr_ctl,
    output logic              wr_sts,
    output logic [REG_W-1:0]  bmask
);
    localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(2);

    logic any_byte;
    assign any_byte = |cfg_be;

    assign wr_vec = cfg_wr && any_byte && (cfg_addr == A_VEC);
    assign wr_ctl = cfg_wr && any_byte && (cfg_addr == A_CTL);
    assign wr_sts = cfg_wr && any_byte && (cfg_addr == A_STS);

    for (genvar i = 0; i < REG_W; i++) begin : g_mask
        assign bmask[i] = cfg_be[i / 8];
    end
endmodule

// File: rtl/hps_slot_regs.sv
module hps_slot_regs
    import hps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_vec,
    input  logic             wr_ctl,
    input  logic             wr_sts,
    input  logic [REG_W-1:0] bmask,
    input  logic [REG_W-1:0] wdata,
    input  logic             hot_add,
    input  logic             button_press,
    output logic [VEC_W-1:0] vec_o,
    output slot_ctl_t        ctl_o,
    output slot_sts_t        sts_o,
    output logic             detach_o,
    output logic             busy_o
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        slot_ctl_t        ctl;
        slot_sts_t        sts;
        logic             detach;
        logic             busy;
    } reg_state_t;

    localparam slot_ctl_t CTL_RST = '{pwr_off: 1'b0, pwr_ind: 2'b00,
                                      attn_ind: IND_OFF, hp_ie: 1'b0,
                                      cc_en: 1'b0, pd_en: 1'b0, ab_en: 1'b0};

    reg_state_t st_d, st_q;
    slot_ctl_t  ctl_w;

    always_comb begin
        st_d        = st_q;
        st_d.detach = 1'b0;
        st_d.busy   = 1'b0;
        ctl_w       = st_q.ctl;

        if (wr_vec) begin
            for (int i = 0; i < VEC_W; i++) begin
                if (bmask[i]) st_d.vec[i] = wdata[i];
            end
        end

        // status: write one to clear on the event bits only
        if (wr_sts) begin
            if (bmask[0] && wdata[0]) st_d.sts.abp = 1'b0;
            if (bmask[1] && wdata[1]) st_d.sts.pdc = 1'b0;
            if (bmask[2] && wdata[2]) st_d.sts.cci = 1'b0;
        end

        // control: every enabled write is one command
        if (wr_ctl) begin
            for (int i = 0; i < CTL_W; i++) begin
                if (bmask[i]) ctl_w[i] = wdata[i];
            end
            st_d.ctl = ctl_w;
            if (bmask[LOCK_BIT] && wdata[LOCK_BIT]) begin
                st_d.sts.lock = ~st_q.sts.lock;
            end
            if (st_q.sts.pds && ctl_w.pwr_off && (ctl_w.pwr_ind == IND_OFF)) begin
                st_d.detach  = 1'b1;
                st_d.sts.pds = 1'b0;
                st_d.sts.pdc = 1'b1;
            end
            st_d.sts.cci = 1'b1;
        end

        if (button_press) st_d.sts.abp = 1'b1;

        if (hot_add) begin
            if (st_q.sts.lock) begin
                st_d.busy = 1'b1;
            end else begin
                st_d.sts.pds = 1'b1;
                st_d.sts.pdc = 1'b1;
                st_d.sts.abp = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vec    <= '0;
            st_q.ctl    <= CTL_RST;
            st_q.sts    <= '0;
            st_q.detach <= 1'b0;
            st_q.busy   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o    = st_q.vec;
    assign ctl_o    = st_q.ctl;
    assign sts_o    = st_q.sts;
    assign detach_o = st_q.detach;
    assign busy_o   = st_q.busy;

    // R7: a control write completes as a command
    a_r7_cmd_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> st_q.sts.cci);

    // R8: interlock toggle inverts the interlock status
    a_r8_lock_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && bmask[LOCK_BIT] && wdata[LOCK_BIT]) |=> (st_q.sts.lock != $past(st_q.sts.lock)));

    // R9: a detach leaves the slot empty with a change flagged
    a_r9_detach_empties: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.detach |-> (!st_q.sts.pds && st_q.sts.pdc));

    // R10: a refused hot-add leaves presence untouched
    a_r10_refused_add: assert property (@(posedge clk) disable iff (!rst_n)
        (hot_add && st_q.sts.lock && !wr_ctl) |=> (st_q.busy && $stable(st_q.sts.pds)));
endmodule

// File: rtl/hps_notify.sv
module hps_notify
    import hps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  slot_ctl_t ctl,
    input  slot_sts_t sts,
    input  logic      msg_enable,
    output logic      irq_o,
    output logic      msg_o
);
    typedef struct packed {
        logic level;
        logic msg;
    } ntf_state_t;

    ntf_state_t nt_d, nt_q;
    logic       level_now;
    logic [2:0] ev_pend;

    assign ev_pend   = {sts.cci & ctl.cc_en, sts.pdc & ctl.pd_en, sts.abp & ctl.ab_en};
    assign level_now = ctl.hp_ie && (|ev_pend);

    always_comb begin
        nt_d       = nt_q;
        nt_d.level = level_now;
        nt_d.msg   = msg_enable && level_now && !nt_q.level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nt_q <= '0;
        end else begin
            nt_q <= nt_d;
        end
    end

    assign irq_o = nt_q.level && !msg_enable;
    assign msg_o = nt_q.msg;

    // R5: a message only follows a rising level
    a_r5_msg_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o |-> (nt_q.level && !$past(nt_q.level)));

    // R5: the message path is used only in message mode
    a_r5_msg_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
        msg_o |-> $past(msg_enable));
endmodule

// File: rtl/hps_slot_ctrl.sv
module hps_slot_ctrl
    import hps_pkg::*;
#(
    parameter int                   ADDR_W  = 2,
    parameter logic [SLOT_ID_W-1:0] SLOT_ID = 11'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BE_W-1:0]   cfg_be,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              msg_enable,
    input  logic              hot_add,
    input  logic              button_press,
    output logic              irq_o,
    output logic              msg_o,
    output logic [VEC_W-1:0]  msg_vec_o,
    output logic              detach_o,
    output logic              add_busy_o
);
    localparam logic [CFG_W-1:0] CAP_VAL = {SLOT_ID, 5'b11111};

    logic             wr_vec, wr_ctl, wr_sts;
    logic [REG_W-1:0] bmask;
    logic [VEC_W-1:0] vec_q;
    slot_ctl_t        ctl_q;
    slot_sts_t        sts_q;
    logic             wdata_unused;

    assign wdata_unused = ^cfg_wdata[CFG_W-1:REG_W];

    hps_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_be   (cfg_be),
        .wr_vec   (wr_vec),
        .wr_ctl   (wr_ctl),
        .wr_sts   (wr_sts),
        .bmask    (bmask)
    );

    hps_slot_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_vec       (wr_vec),
        .wr_ctl       (wr_ctl),
        .wr_sts       (wr_sts),
        .bmask        (bmask),
        .wdata        (cfg_wdata[REG_W-1:0]),
        .hot_add      (hot_add),
        .button_press (button_press),
        .vec_o        (vec_q),
        .ctl_o        (ctl_q),
        .sts_o        (sts_q),
        .detach_o     (detach_o),
        .busy_o       (add_busy_o)
    );

    hps_notify u_ntf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl_q),
        .sts        (sts_q),
        .msg_enable (msg_enable),
        .irq_o      (irq_o),
        .msg_o      (msg_o)
    );

    assign msg_vec_o = vec_q;

    // the interlock toggle is never stored, so it reads as zero
    always_comb begin
        case (cfg_addr)
            ADDR_W'(0): cfg_rdata = CFG_W'(vec_q);
            ADDR_W'(1): cfg_rdata = CFG_W'(ctl_q);
            ADDR_W'(2): cfg_rdata = CFG_W'(sts_q);
            ADDR_W'(3): cfg_rdata = CAP_VAL;
            default:    cfg_rdata = '0;
        endcase
    end

    // R4: the legacy line stays quiet while messages are in use
    a_r4_line_quiet_in_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_enable && $past(msg_enable)) |-> !irq_o);
endmodule

// File: tb/hps_slot_ctrl_tb_top.sv
`timescale 1ns/100ps
module hps_slot_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [1:0]  cfg_be = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        msg_enable = 1'b0;
    logic        hot_add = 1'b0;
    logic        button_press = 1'b0;
    logic        irq_o, msg_o, detach_o, add_busy_o;
    logic [4:0]  msg_vec_o;

    int checks = 0;
    int errors = 0;
    int msg_cnt = 0;
    int det_cnt = 0;
    int busy_cnt = 0;
    logic [4:0] last_vec = 5'd0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hps_slot_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .msg_enable(msg_enable), .hot_add(hot_add), .button_press(button_press),
        .irq_o(irq_o), .msg_o(msg_o), .msg_vec_o(msg_vec_o),
        .detach_o(detach_o), .add_busy_o(add_busy_o)
    );

    always @(posedge clk) begin
        if (msg_o) begin msg_cnt++; last_vec = msg_vec_o; end
        if (detach_o) det_cnt++;
        if (add_busy_o) busy_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 2'b00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic press();
        @(negedge clk); button_press = 1'b1;
        @(negedge clk); button_press = 1'b0;
    endtask

    task automatic add();
        @(negedge clk); hot_add = 1'b1;
        @(negedge clk); hot_add = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic [8:0] ctl;
        logic [1:0] evt;   // 0 none, 1 button, 2 hot-add
        logic       exp_irq;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{9'h008, 2'd1, 1'b0},  // global enable only
        '{9'h009, 2'd1, 1'b1},  // button enabled
        '{9'h001, 2'd1, 1'b0},  // no global enable
        '{9'h00C, 2'd0, 1'b1},  // command done from the write itself
        '{9'h00A, 2'd0, 1'b0},  // presence enable, nothing pending
        '{9'h00A, 2'd2, 1'b1},  // presence enable, hot-add
        '{9'h00B, 2'd1, 1'b1},  // two enables, button
        '{9'h002, 2'd2, 1'b0}   // presence without global enable
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int m0, d0, b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values and map
        rd(2'd1, d); chk("R1 ctl reset", d, 16'h0030);
        rd(2'd2, d); chk("R1 sts reset", d, 16'h0000);
        rd(2'd0, d); chk("R1 vec reset", d, 16'h0000);
        rd(2'd3, d); chk("R1 capability", d, 16'h00BF);
        chk("R1 irq reset", irq_o, 0);

        // R3 R4 table of notification cases (legacy mode)
        for (int k = 0; k < 8; k++) begin
            wr(2'd2, 16'h0007, 2'b01);
            wr(2'd1, {7'd0, TBL[k].ctl}, 2'b11);
            if (TBL[k].evt == 2'd1) press();
            else if (TBL[k].evt == 2'd2) add();
            settle();
            chk($sformatf("R3 R4 level vector %0d", k), irq_o, TBL[k].exp_irq);
        end

        // R2 write-one-to-clear and read-only bits
        wr(2'd1, 16'h0000, 2'b11);
        press();
        wr(2'd2, 16'h0001, 2'b00);
        rd(2'd2, d); chk("R2 no-byte write keeps abp", d[0], 1);
        wr(2'd2, 16'h0018, 2'b01);
        rd(2'd2, d); chk("R2 presence state ignores write", d[3], 1);
        chk("R2 abp untouched by other bits", d[0], 1);
        wr(2'd2, 16'h0001, 2'b01);
        rd(2'd2, d); chk("R2 abp cleared", d[0], 0);

        // R7 commands
        wr(2'd2, 16'h0007, 2'b01);
        wr(2'd1, 16'h0000, 2'b00);
        rd(2'd2, d); chk("R7 no-byte write not a command", d[2], 0);
        wr(2'd1, 16'h0000, 2'b10);
        rd(2'd2, d); chk("R7 upper byte write is a command", d[2], 1);

        // R10 hot-add sets three bits
        wr(2'd2, 16'h0007, 2'b01);
        add();
        rd(2'd2, d); chk("R10 hot-add status", d, 16'h000B);

        // R8 interlock toggle and refused hot-add
        wr(2'd1, 16'h0200, 2'b10);
        rd(2'd2, d); chk("R8 lock engaged", d[4], 1);
        rd(2'd1, d); chk("R8 toggle reads zero", d[9], 0);
        wr(2'd2, 16'h0007, 2'b01);
        b0 = busy_cnt;
        add();
        @(negedge clk);
        chk("R10 busy pulse when locked", busy_cnt - b0, 1);
        rd(2'd2, d); chk("R10 refused add leaves status", d[2:0], 0);
        wr(2'd1, 16'h0200, 2'b10);
        rd(2'd2, d); chk("R8 lock released", d[4], 0);

        // R9 detach
        d0 = det_cnt;
        wr(2'd1, 16'h0140, 2'b11);
        @(negedge clk);
        chk("R9 no detach with indicator on", det_cnt - d0, 0);
        wr(2'd2, 16'h0007, 2'b01);
        wr(2'd1, 16'h01C0, 2'b11);
        @(negedge clk);
        chk("R9 detach pulse", det_cnt - d0, 1);
        rd(2'd2, d); chk("R9 presence cleared", d[3], 0);
        chk("R9 presence changed", d[1], 1);
        wr(2'd1, 16'h01C0, 2'b11);
        @(negedge clk);
        chk("R9 empty slot no detach", det_cnt - d0, 1);

        // R5 R6 R11 message path
        msg_enable = 1'b1;
        wr(2'd0, 16'h0013, 2'b01);
        wr(2'd1, 16'h0031, 2'b11);
        wr(2'd2, 16'h0007, 2'b01);
        m0 = msg_cnt;
        press();
        settle();
        chk("R6 no message while disabled", msg_cnt - m0, 0);
        wr(2'd1, 16'h0039, 2'b11);
        settle();
        chk("R6 late notification", msg_cnt - m0, 1);
        chk("R5 vector", last_vec, 5'h13);
        chk("R5 line quiet in message mode", irq_o, 0);
        press();
        settle();
        chk("R11 repeat press no message", msg_cnt - m0, 1);
        wr(2'd2, 16'h0007, 2'b01);
        settle();
        chk("R5 falling level no message", msg_cnt - m0, 1);
        press();
        settle();
        chk("R5 new rise new message", msg_cnt - m0, 2);

        // R12 legacy drop on status clear
        msg_enable = 1'b0;
        settle();
        chk("R4 line follows level", irq_o, 1);
        wr(2'd2, 16'h0001, 2'b01);
        settle();
        chk("R12 line drops after clear", irq_o, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule